// File: doc/BRIEF.md
# Dual-Mode Parallel Host Bus Interface

This block lets a host processor reach the registers of a multi-channel device over an asynchronous 8-bit parallel bus. The bus has a 13-bit address and a separate data path; address and data are never multiplexed. A strap input picks the strobe style. In one style the host uses separate active-low read and write strobes. In the other, a level gives the direction (read when high, write when low) and an active-low data strobe times the access. The strobe inputs and the select input are brought into the core clock domain through two-flop synchronisers. A write is committed exactly once, when the synchronised strobe goes back high.

The register space holds four identical channel copies plus a global region. A global control bit can turn on broadcast writes, where one host write lands in the same register of all four channels. This speeds up the bring-up of a device. Reads always come from the addressed channel. Each channel has sticky interrupt status bits and a mask register. The block merges all unmasked pending bits into one open-drain pull-down enable, which the pad turns into an active-low request line.

Top module: `hbus_host_if`

## Requirements
- R1: With `bus_mode` = 0, `strb_a` is an active-low read strobe and `strb_b_n` is an active-low write strobe. A write followed by a read at the same address returns the written byte.
- R2: With `bus_mode` = 1, `strb_a` is a read/not-write level (1 = read) and `strb_b_n` is an active-low data strobe. Write and read-back work the same way as in R1.
- R3: While `cs_n` is high, a strobe neither changes any register nor enables the data output.
- R4: A write takes effect only after the synchronised strobe deasserts. While the strobe is still held low, the target register keeps its old value.
- R5: Address decode works as follows. `addr[12]` = 1 selects the channel region, `addr[9:8]` selects the channel, and `addr[7:0]` is the offset. Offsets 0 to 3 are storage registers, 0xF0 is interrupt status and 0xF1 is interrupt mask. `addr[12]` = 0 with all other bits 0 is the global control register. Any other address reads as 0.
- R6: While bit 2 of global control is set, each channel-region write updates the same offset in all four channels.
- R7: Reads return the addressed channel's own register even while broadcast is enabled.
- R8: After bit 2 of global control is cleared, a channel-region write updates only the addressed channel.
- R9: `host_doe` is 1 only while a select and a read are both active, and `host_dout` carries the read byte. Otherwise `host_doe` and `host_dout` are 0.
- R10: A one-cycle pulse on `irq_evt[ch*8+i]` sets bit i of that channel's status register, and the bit stays set. Writing 1 to the bit clears it. Writing 0 leaves it unchanged.
- R11: `irq_pull` is 1 (pad pulls the request line low) exactly when some status bit is set and its mask bit is 1.
- R12: After reset, all registers are 0, and `host_doe` and `irq_pull` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_mode | input | 1 | Strobe style strap: 0 = separate strobes, 1 = direction level plus data strobe |
| cs_n | input | 1 | Active-low chip select |
| strb_a | input | 1 | Read strobe (mode 0, active low) or read/not-write level (mode 1) |
| strb_b_n | input | 1 | Write strobe (mode 0) or data strobe (mode 1), active low |
| addr | input | 13 | Register address |
| host_din | input | 8 | Write data from the host |
| host_dout | output | 8 | Read data toward the pad |
| host_doe | output | 1 | Data pad output enable |
| irq_evt | input | 32 | Interrupt event pulses, 8 per channel |
| irq_pull | output | 1 | Open-drain pull-down enable for the request line |

## Verification
The main path is tried with writes and read-backs in both strobe styles at several channels and offsets. A read of an untouched channel tells channel decode apart from a shared register. Distinct per-channel values written before broadcast is turned on tell broadcast writes apart from broadcast reads. Values written after broadcast is turned off show whether the enable bit really gates the fan-out. A write strobe held low against the interrupt status shows whether commit waits for the strobe edge, since the request line must stay asserted until the strobe is released.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int ADDR_W    = 13;
  localparam int DATA_W    = 8;
  localparam int NCH       = 4;
  localparam int OFS_W     = 8;
  localparam int CH_W      = $clog2(NCH);
  localparam int NREG      = 4;
  localparam int NSRC      = 8;
  localparam int BCAST_BIT = 2;
  localparam logic [OFS_W-1:0] OFS_STAT = 8'hF0;
  localparam logic [OFS_W-1:0] OFS_MASK = 8'hF1;

  function automatic logic in_chan_region(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1];
  endfunction

  function automatic logic [CH_W-1:0] chan_of(logic [ADDR_W-1:0] a);
    return a[OFS_W +: CH_W];
  endfunction

  function automatic logic [OFS_W-1:0] ofs_of(logic [ADDR_W-1:0] a);
    return a[OFS_W-1:0];
  endfunction

  function automatic logic is_global_ctrl(logic [ADDR_W-1:0] a);
    return a == '0;
  endfunction

  // Channels touched by a write: none outside the channel region, all four
  // when broadcasting, otherwise the one picked by the channel field.
  function automatic logic [NCH-1:0] chan_sel(logic [ADDR_W-1:0] a, logic bcast);
    logic [NCH-1:0] one;
    one = 1;
    if (!in_chan_region(a)) return '0;
    if (bcast) return '1;
    return one << chan_of(a);
  endfunction
endpackage

// File: rtl/hbus_strobe_sync.sv
module hbus_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_mode,
  input  logic cs_n,
  input  logic strb_a,
  input  logic strb_b_n,
  output logic rd_active,
  output logic wr_commit
);
  logic [SYNC_STAGES-1:0] cs_sr, a_sr, b_sr;
  logic cs_s, a_s, b_s;
  logic cs_q, a_q, b_q;
  logic b_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sr <= '1;
      a_sr  <= '1;
      b_sr  <= '1;
      cs_q  <= 1'b1;
      a_q   <= 1'b1;
      b_q   <= 1'b1;
    end else begin
      cs_sr <= {cs_sr[SYNC_STAGES-2:0], cs_n};
      a_sr  <= {a_sr[SYNC_STAGES-2:0], strb_a};
      b_sr  <= {b_sr[SYNC_STAGES-2:0], strb_b_n};
      cs_q  <= cs_s;
      a_q   <= a_s;
      b_q   <= b_s;
    end
  end

  assign cs_s   = cs_sr[SYNC_STAGES-1];
  assign a_s    = a_sr[SYNC_STAGES-1];
  assign b_s    = b_sr[SYNC_STAGES-1];
  assign b_rise = b_s && !b_q;

  always_comb begin
    if (!bus_mode) begin
      rd_active = !cs_s && !a_s;
      wr_commit = b_rise && !cs_q;
    end else begin
      rd_active = !cs_s && !b_s && a_s;
      wr_commit = b_rise && !cs_q && !a_q;
    end
  end

  // R4: one commit per strobe release
  assert_commit_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);
endmodule

// File: rtl/hbus_chan_regs.sv
module hbus_chan_regs
  import hbus_pkg::*;
#(
  parameter int N_REG = NREG,
  parameter int N_SRC = NSRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_SRC-1:0]  evt,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int IDX_W = $clog2(N_REG);

  logic [DATA_W-1:0] regs [N_REG];
  logic [N_SRC-1:0]  stat, mask;
  logic              w1c, mask_we;
  logic [N_SRC-1:0]  clr_bits;

  assign w1c      = we && (ofs == OFS_STAT);
  assign mask_we  = we && (ofs == OFS_MASK);
  assign clr_bits = w1c ? wdata[N_SRC-1:0] : '0;

  generate
    for (genvar r = 0; r < N_REG; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs[r] <= '0;
        else if (we && (ofs == OFS_W'(r))) regs[r] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      mask <= '0;
    end else begin
      stat <= (stat & ~clr_bits) | evt;
      if (mask_we) mask <= wdata[N_SRC-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (ofs < OFS_W'(N_REG))   rdata = regs[ofs[IDX_W-1:0]];
    else if (ofs == OFS_STAT)  rdata = DATA_W'(stat);
    else if (ofs == OFS_MASK)  rdata = DATA_W'(mask);
  end

  assign irq = |(stat & mask);

  // R10: pending bits survive any cycle without a clearing write
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !w1c |=> ((stat & $past(stat)) == $past(stat)));
  // R10: an event always lands in status
  assert_evt_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat & $past(evt)) == $past(evt)));
endmodule

// File: rtl/hbus_host_if.sv
module hbus_host_if
  import hbus_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_mode,
  input  logic                   cs_n,
  input  logic                   strb_a,
  input  logic                   strb_b_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      host_din,
  output logic [DATA_W-1:0]      host_dout,
  output logic                   host_doe,
  input  logic [NCH*NSRC-1:0]    irq_evt,
  output logic                   irq_pull
);
  logic              rd_active, wr_commit;
  logic [DATA_W-1:0] gctrl;
  logic              bcast_en, glob_we;
  logic [NCH-1:0]    chan_we, irq_ch;
  logic [DATA_W-1:0] rdata_ch [NCH];
  logic [DATA_W-1:0] rmux;

  hbus_strobe_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n),
    .strb_a(strb_a), .strb_b_n(strb_b_n),
    .rd_active(rd_active), .wr_commit(wr_commit)
  );

  assign bcast_en = gctrl[BCAST_BIT];
  assign glob_we  = wr_commit && is_global_ctrl(addr);
  assign chan_we  = wr_commit ? chan_sel(addr, bcast_en) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gctrl <= '0;
    else if (glob_we) gctrl <= host_din;
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      hbus_chan_regs #(.N_REG(NREG), .N_SRC(NSRC)) u_ch (
        .clk(clk), .rst_n(rst_n), .we(chan_we[c]), .ofs(ofs_of(addr)),
        .wdata(host_din), .evt(irq_evt[c*NSRC +: NSRC]),
        .rdata(rdata_ch[c]), .irq(irq_ch[c])
      );
    end
  endgenerate

  always_comb begin
    if (in_chan_region(addr))      rmux = rdata_ch[chan_of(addr)];
    else if (is_global_ctrl(addr)) rmux = gctrl;
    else                           rmux = '0;
  end

  assign host_doe  = rd_active;
  assign host_dout = rd_active ? rmux : '0;
  assign irq_pull  = |irq_ch;

  // R9: output enable only follows a synchronised, asserted select
  assert_doe_needs_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_doe |-> !$past(cs_n, 2));
  // R8: without broadcast at most one channel is written
  assert_single_chan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && !bcast_en) |-> $onehot0(chan_we));
  // R6: broadcast write reaches every channel
  assert_bcast_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && bcast_en && addr[ADDR_W-1]) |-> ($countones(chan_we) == NCH));
  // R3: no write strobe commit without a select seen beforehand
  assert_no_commit_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !$past(cs_n, 3));
endmodule

// File: tb/tb_hbus_host_if.sv
module tb_hbus_host_if;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_mode = 0;
  logic        cs_n = 1, strb_a = 1, strb_b_n = 1;
  logic [12:0] addr = '0;
  logic [7:0]  host_din = '0;
  logic [7:0]  host_dout;
  logic        host_doe;
  logic [31:0] irq_evt = '0;
  logic        irq_pull;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  hbus_host_if dut (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n),
    .strb_a(strb_a), .strb_b_n(strb_b_n), .addr(addr), .host_din(host_din),
    .host_dout(host_dout), .host_doe(host_doe), .irq_evt(irq_evt),
    .irq_pull(irq_pull)
  );

  typedef struct packed {
    logic        md;
    logic        wr;
    logic [12:0] a;
    logic [7:0]  d;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 13'h1000, 8'h11, 8'd1},   // R1 write ch0 off0
    '{1'b0, 1'b0, 13'h1000, 8'h11, 8'd1},   // R1 read back
    '{1'b1, 1'b1, 13'h1101, 8'h22, 8'd2},   // R2 write ch1 off1
    '{1'b1, 1'b0, 13'h1101, 8'h22, 8'd2},   // R2 read back
    '{1'b0, 1'b1, 13'h1302, 8'h33, 8'd5},   // R5 ch3 off2
    '{1'b0, 1'b0, 13'h1002, 8'h00, 8'd5},   // R5 ch0 untouched
    '{1'b0, 1'b0, 13'h1302, 8'h33, 8'd5},
    '{1'b0, 1'b0, 13'h1005, 8'h00, 8'd5},   // R5 unmapped offset
    '{1'b0, 1'b1, 13'h1001, 8'hA0, 8'd7},
    '{1'b0, 1'b1, 13'h1201, 8'hA2, 8'd7},
    '{1'b1, 1'b1, 13'h0000, 8'h04, 8'd6},   // R6 broadcast on
    '{1'b1, 1'b0, 13'h0000, 8'h04, 8'd6},
    '{1'b0, 1'b1, 13'h1103, 8'h5A, 8'd6},   // R6 one write
    '{1'b0, 1'b0, 13'h1003, 8'h5A, 8'd6},
    '{1'b0, 1'b0, 13'h1103, 8'h5A, 8'd6},
    '{1'b1, 1'b0, 13'h1203, 8'h5A, 8'd6},
    '{1'b1, 1'b0, 13'h1303, 8'h5A, 8'd6},
    '{1'b0, 1'b0, 13'h1001, 8'hA0, 8'd7},   // R7 per-channel reads
    '{1'b0, 1'b0, 13'h1201, 8'hA2, 8'd7},
    '{1'b1, 1'b0, 13'h1101, 8'h22, 8'd7},
    '{1'b0, 1'b1, 13'h0000, 8'h00, 8'd8},   // R8 broadcast off
    '{1'b0, 1'b1, 13'h1203, 8'h77, 8'd8},
    '{1'b0, 1'b0, 13'h1203, 8'h77, 8'd8},
    '{1'b0, 1'b0, 13'h1003, 8'h5A, 8'd8},
    '{1'b0, 1'b0, 13'h1303, 8'h5A, 8'd8}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_start(input logic md, input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_mode = md; addr = a; host_din = d; cs_n = 0;
    if (md) strb_a = 0;
    clocks(2);
    strb_b_n = 0;
  endtask

  task automatic wr_end();
    @(negedge clk);
    strb_b_n = 1;
    clocks(4);
    cs_n = 1; strb_a = 1;
    clocks(2);
  endtask

  task automatic host_write(input logic md, input logic [12:0] a, input logic [7:0] d);
    wr_start(md, a, d);
    clocks(4);
    wr_end();
  endtask

  task automatic host_read(input logic md, input logic [12:0] a,
                           output logic [7:0] d, output logic oe);
    @(negedge clk);
    bus_mode = md; addr = a; cs_n = 0;
    if (md) begin strb_a = 1; strb_b_n = 0; end
    else    strb_a = 0;
    clocks(5);
    d = host_dout; oe = host_doe;
    strb_a = 1; strb_b_n = 1;
    clocks(3);
    cs_n = 1;
    clocks(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic       oe;
    clocks(3);
    rst_n = 1;
    clocks(2);

    // R12 reset state
    check("R12 doe", {7'd0, host_doe}, 8'h00);
    check("R12 irq", {7'd0, irq_pull}, 8'h00);
    host_read(1'b0, 13'h1000, rd, oe);
    check("R12 reg", rd, 8'h00);
    check("R9 doe during read", {7'd0, oe}, 8'h01);
    check("R9 doe idle", {7'd0, host_doe}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) host_write(VECS[i].md, VECS[i].a, VECS[i].d);
      else begin
        host_read(VECS[i].md, VECS[i].a, rd, oe);
        check($sformatf("R%0d vec %0d", VECS[i].req, i), rd, VECS[i].d);
      end
    end

    // R3: strobes with select high
    @(negedge clk);
    bus_mode = 0; addr = 13'h1000; host_din = 8'hEE; cs_n = 1;
    strb_b_n = 0; clocks(5); strb_b_n = 1; clocks(5);
    strb_a = 0; clocks(5);
    check("R3 doe without cs", {7'd0, host_doe}, 8'h00);
    strb_a = 1; clocks(3);
    host_read(1'b0, 13'h1000, rd, oe);
    check("R3 reg unchanged", rd, 8'h11);

    // R10 / R11 interrupts on ch1 bit 3
    @(negedge clk); irq_evt[1*8+3] = 1'b1;
    @(negedge clk); irq_evt = '0;
    clocks(2);
    host_read(1'b0, 13'h11F0, rd, oe);
    check("R10 status set", rd, 8'h08);
    check("R11 masked", {7'd0, irq_pull}, 8'h00);
    host_write(1'b1, 13'h11F1, 8'h08);
    check("R11 unmasked", {7'd0, irq_pull}, 8'h01);
    host_write(1'b0, 13'h11F0, 8'h00);
    host_read(1'b1, 13'h11F0, rd, oe);
    check("R10 write 0 keeps", rd, 8'h08);

    // R4: clearing write held open, commit only on release
    wr_start(1'b0, 13'h11F0, 8'h08);
    clocks(8);
    check("R4 held strobe", {7'd0, irq_pull}, 8'h01);
    wr_end();
    check("R4 after release", {7'd0, irq_pull}, 8'h00);
    host_read(1'b0, 13'h11F0, rd, oe);
    check("R10 w1c cleared", rd, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule